// File: doc/BRIEF.md
# Grayscale palette pixel unpacker

This block sits between a display word FIFO and a panel driver. It pulls 32-bit words through a pop handshake, splits each word into packed pixels of 1, 2 or 4 bits, and sends each pixel value through a sixteen-entry palette that yields a 4-bit gray level. One pixel is consumed for each pixel-clock enable. The result leaves the block as a registered gray level with a one-cycle valid strobe.

Within a word, pixels are taken from the least significant end upward. A line of the picture is therefore a run of consecutive words. The palette is held in two 32-bit registers that the surrounding logic drives. Every pixel depth indexes the same sixteen entries, so any pixel value at any depth can be given any gray level. The depth is sampled only when a word is loaded, so a word is always decoded with a single depth.

Top module: `gray_unpacker`

## Requirements
- R1: While reset is applied, `gray_vld_o` and `gray_o` are 0 and `pop_o` stays low even if a word is available. These outputs stay at 0 after reset until the first pixel is produced.
- R2: In 4-bit mode (`bpp_i` = 2'b10, or 2'b11, which is treated the same way), pixel k of a word (k = 0..7) is bits [4k+3:4k]. Pixels are produced in increasing k.
- R3: In 2-bit mode (`bpp_i` = 2'b01), pixel k (k = 0..15) is bits [2k+1:2k]. Its value selects palette entries 0 to 3. Pixels are produced in increasing k.
- R4: In 1-bit mode (`bpp_i` = 2'b00), pixel k (k = 0..31) is bit k. Its value selects palette entry 0 or 1. Pixels are produced in increasing k.
- R5: Palette entry n is bits [4n+3:4n] of the 64-bit value {`pal_hi_i`, `pal_lo_i`}. Entries 0 to 7 therefore come from `pal_lo_i` and entries 8 to 15 from `pal_hi_i`. The palette is read in the cycle the pixel is consumed.
- R6: `pop_o` is high only when `word_avail_i` is high. It rises when no word is held, or in the same cycle as the enable that consumes the last pixel of the held word. Each word therefore yields exactly 8, 16 or 32 pixels for 4, 2 or 1 bits per pixel.
- R7: `bpp_i` is sampled only in a cycle where `pop_o` is high. Changing it at any other time has no effect on the word being decoded.
- R8: `gray_o` and `gray_vld_o` are registered. `gray_vld_o` is high for exactly one cycle after each enabled cycle in which a word is held. An enable while no word is held produces no valid output and consumes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| word_i | input | 32 | Head word of the display FIFO |
| word_avail_i | input | 1 | FIFO holds at least one word |
| pop_o | output | 1 | Takes `word_i` at this clock edge |
| bpp_i | input | 2 | Pixel depth: 00 = 1 bit, 01 = 2 bits, 10 or 11 = 4 bits |
| pal_lo_i | input | 32 | Palette entries 0 to 7 |
| pal_hi_i | input | 32 | Palette entries 8 to 15 |
| pix_en_i | input | 1 | Pixel-clock enable; consumes one pixel |
| gray_o | output | 4 | Gray level of the last consumed pixel |
| gray_vld_o | output | 1 | `gray_o` was updated at the last edge |

## Verification
The two functions that can land in the same cycle are emitting the last pixel of the held word and popping its successor, which also loads a new depth. The bench keeps the enable high and the FIFO non-empty for long runs. It also changes the depth on every cycle, so each word boundary lines up with both a final pixel and a depth change. The result is judged at the outputs. Every valid gray level must match, in order, a queue of pixel indices that the bench computed from each popped word and the depth present at its pop. A gray level that appears with nothing pending, or a queue that is not empty once the FIFO runs dry, counts as a failure.

// File: rtl/gup_pkg.sv
package gup_pkg;
  typedef enum logic [1:0] {
    BPP1  = 2'b00,
    BPP2  = 2'b01,
    BPP4  = 2'b10,
    BPP4X = 2'b11
  } bpp_e;
endpackage

// File: rtl/gup_rst_sync.sv
module gup_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_ns = s1_q;
endmodule

// File: rtl/gup_word_hold.sv
module gup_word_hold
  import gup_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_avail_i,
  input  logic              pix_en_i,
  input  bpp_e              bpp_i,
  output logic              pop_o,
  output logic              take_o,
  output logic [WORD_W-1:0] word_q,
  output bpp_e              mode_q,
  output logic [IDX_W-1:0]  idx_q
);
  localparam logic [IDX_W-1:0] LAST1 = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] LAST2 = IDX_W'(WORD_W / 2 - 1);
  localparam logic [IDX_W-1:0] LAST4 = IDX_W'(WORD_W / 4 - 1);

  logic             rdy_q;
  logic             loaded_q, loaded_d;
  logic             at_last;
  logic [IDX_W-1:0] last_idx, idx_d;

  always_comb begin
    case (mode_q)
      BPP1:    last_idx = LAST1;
      BPP2:    last_idx = LAST2;
      default: last_idx = LAST4;
    endcase
  end

  always_comb begin
    take_o   = pix_en_i && loaded_q;
    at_last  = (idx_q == last_idx);
    pop_o    = rdy_q && word_avail_i && (!loaded_q || (take_o && at_last));
    loaded_d = loaded_q;
    idx_d    = idx_q;
    if (take_o) begin
      idx_d = idx_q + 1'b1;
      if (at_last) loaded_d = 1'b0;
    end
    if (pop_o) begin
      loaded_d = 1'b1;
      idx_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q    <= 1'b0;
      loaded_q <= 1'b0;
      idx_q    <= '0;
      word_q   <= '0;
      mode_q   <= BPP4;
    end else begin
      rdy_q    <= 1'b1;
      loaded_q <= loaded_d;
      idx_q    <= idx_d;
      if (pop_o) begin
        word_q <= word_i;
        mode_q <= bpp_i;
      end
    end
  end

  // R6: a pop starts a fresh word at pixel 0
  assert_pop_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o |=> (loaded_q && idx_q == '0));

  // R6: pop only with a word on offer
  assert_pop_needs_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o |-> word_avail_i);

  // R7: depth only changes at a pop
  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_o |=> $stable(mode_q));

  // R2: pixel index stays inside the held word
  assert_idx_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |-> (idx_q <= last_idx));
endmodule

// File: rtl/gup_pix_sel.sv
module gup_pix_sel
  import gup_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = $clog2(WORD_W),
  parameter int PIX_W  = 4
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  bpp_e              mode_i,
  output logic [PIX_W-1:0]  pix_o
);
  logic [PIX_W-1:0] cand [3];

  for (genvar g = 0; g < 3; g++) begin : g_depth
    localparam int W  = 1 << g;
    localparam int N  = WORD_W / W;
    localparam int SW = $clog2(N);
    logic [W-1:0] lane [N];
    for (genvar k = 0; k < N; k++) begin : g_lane
      assign lane[k] = word_i[k*W +: W];
    end
    assign cand[g] = PIX_W'(lane[idx_i[SW-1:0]]);
  end

  always_comb begin
    case (mode_i)
      BPP1:    pix_o = cand[0];
      BPP2:    pix_o = cand[1];
      default: pix_o = cand[2];
    endcase
  end
endmodule

// File: rtl/gup_palette.sv
module gup_palette #(
  parameter int NENT   = 16,
  parameter int GRAY_W = 4,
  parameter int SEL_W  = $clog2(NENT),
  parameter int HALF_W = NENT * GRAY_W / 2
) (
  input  logic [HALF_W-1:0] pal_lo_i,
  input  logic [HALF_W-1:0] pal_hi_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [GRAY_W-1:0] gray_o
);
  logic [GRAY_W-1:0] ent [NENT];

  for (genvar n = 0; n < NENT; n++) begin : g_ent
    if (n < NENT / 2) begin : g_lo
      assign ent[n] = pal_lo_i[n*GRAY_W +: GRAY_W];
    end else begin : g_hi
      assign ent[n] = pal_hi_i[(n-NENT/2)*GRAY_W +: GRAY_W];
    end
  end

  assign gray_o = ent[sel_i];
endmodule

// File: rtl/gray_unpacker.sv
module gray_unpacker
  import gup_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int GRAY_W = 4,
  parameter int NENT   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WORD_W-1:0]          word_i,
  input  logic                       word_avail_i,
  output logic                       pop_o,
  input  logic [1:0]                 bpp_i,
  input  logic [NENT*GRAY_W/2-1:0]   pal_lo_i,
  input  logic [NENT*GRAY_W/2-1:0]   pal_hi_i,
  input  logic                       pix_en_i,
  output logic [GRAY_W-1:0]          gray_o,
  output logic                       gray_vld_o
);
  localparam int PIX_W  = $clog2(NENT);
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int HALF_W = NENT * GRAY_W / 2;

  logic              rst_ns;
  logic              take;
  logic [WORD_W-1:0] word_q;
  bpp_e              mode_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PIX_W-1:0]  pix;
  logic [GRAY_W-1:0] lut, gray_d;
  logic              vld_d;

  gup_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  gup_word_hold #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_hold (
    .clk          (clk),
    .rst_n        (rst_ns),
    .word_i       (word_i),
    .word_avail_i (word_avail_i),
    .pix_en_i     (pix_en_i),
    .bpp_i        (bpp_e'(bpp_i)),
    .pop_o        (pop_o),
    .take_o       (take),
    .word_q       (word_q),
    .mode_q       (mode_q),
    .idx_q        (idx_q)
  );

  gup_pix_sel #(.WORD_W(WORD_W), .IDX_W(IDX_W), .PIX_W(PIX_W)) u_sel (
    .word_i (word_q),
    .idx_i  (idx_q),
    .mode_i (mode_q),
    .pix_o  (pix)
  );

  gup_palette #(.NENT(NENT), .GRAY_W(GRAY_W), .SEL_W(PIX_W), .HALF_W(HALF_W)) u_pal (
    .pal_lo_i (pal_lo_i),
    .pal_hi_i (pal_hi_i),
    .sel_i    (pix),
    .gray_o   (lut)
  );

  always_comb begin
    vld_d  = take;
    gray_d = take ? lut : gray_o;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      gray_o     <= '0;
      gray_vld_o <= 1'b0;
    end else begin
      gray_vld_o <= vld_d;
      if (take) gray_o <= gray_d;
    end
  end

  // R8: one strobe per consumed pixel, one cycle later
  assert_vld_after_take_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    take |=> gray_vld_o);

  assert_no_vld_idle_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    !take |=> !gray_vld_o);

  // R8: gray level holds while nothing is consumed
  assert_gray_hold_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    !take |=> $stable(gray_o));

  // R1: no pop while the internal reset is held
  assert_no_pop_in_reset_R1: assert property (@(posedge clk)
    !rst_ns |-> !pop_o);
endmodule

// File: tb/gray_unpacker_bench.sv
`timescale 1ns/1ps
module gray_unpacker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] word_i;
  logic        word_avail_i;
  logic        pop_o;
  logic [1:0]  bpp_i;
  logic [31:0] pal_lo_i, pal_hi_i;
  logic        pix_en_i;
  logic [3:0]  gray_o;
  logic        gray_vld_o;

  always #2.5 clk = ~clk;

  gray_unpacker u_gray_unpacker (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .word_avail_i(word_avail_i),
    .pop_o(pop_o), .bpp_i(bpp_i), .pal_lo_i(pal_lo_i), .pal_hi_i(pal_hi_i),
    .pix_en_i(pix_en_i), .gray_o(gray_o), .gray_vld_o(gray_vld_o)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;
  int q[$];
  logic [31:0] lcg = 32'h1234_5678;
  logic [31:0] cur_word = 32'h7654_3210;

  function automatic logic [31:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // queue entry: nbits*64 + pixel index
  task automatic push_word(input logic [31:0] w, input logic [1:0] b);
    int nb = (b == 2'b00) ? 1 : (b == 2'b01) ? 2 : 4;
    for (int k = 0; k < 32 / nb; k++)
      q.push_back(nb * 64 + int'((w >> (k * nb)) & ((32'd1 << nb) - 1)));
  endtask

  task automatic tick(input logic en, input logic av, input logic [1:0] b,
                      input logic [31:0] plo, input logic [31:0] phi);
    @(negedge clk);
    if (gray_vld_o) begin
      if (q.size() == 0) chk(1'b0, "R8 valid with nothing pending", 1, 0);
      else begin
        int e = q.pop_front();
        int nb = e / 64;
        int ix = e % 64;
        logic [63:0] p = {pal_hi_i, pal_lo_i};
        int exp = int'((p >> (4 * ix)) & 64'hF);
        if (nb == 1)      chk(gray_o == exp[3:0], "R4/R5 1-bit pixel gray", gray_o, exp);
        else if (nb == 2) chk(gray_o == exp[3:0], "R3/R5 2-bit pixel gray", gray_o, exp);
        else              chk(gray_o == exp[3:0], "R2/R5 4-bit pixel gray", gray_o, exp);
      end
    end
    pix_en_i = en; word_avail_i = av; bpp_i = b;
    pal_lo_i = plo; pal_hi_i = phi; word_i = cur_word;
    #1;
    if (pop_o) begin
      chk(av, "R6 pop without available word", 1, int'(av));
      push_word(cur_word, b);
      cur_word = rnd();
    end
  endtask

  task automatic drain(input logic [31:0] plo, input logic [31:0] phi);
    for (int i = 0; i < 40; i++) tick(1'b1, 1'b0, 2'b10, plo, phi);
    chk(q.size() == 0, "R6 pixels per word", q.size(), 0);
    tick(1'b1, 1'b0, 2'b00, plo, phi);
    chk(gray_vld_o == 1'b0, "R8 enable with no word held", gray_vld_o, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] plo, phi;
    rst_n = 1'b0; pix_en_i = 1'b0; word_avail_i = 1'b0; bpp_i = 2'b10;
    pal_lo_i = '0; pal_hi_i = '0; word_i = '0;
    repeat (3) @(negedge clk);
    word_avail_i = 1'b1;
    #1;
    chk(pop_o == 1'b0, "R1 no pop during reset", pop_o, 0);
    chk(gray_vld_o == 1'b0, "R1 valid low in reset", gray_vld_o, 0);
    chk(gray_o == 4'd0, "R1 gray zero in reset", gray_o, 0);
    word_avail_i = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    plo = 32'hFEDC_BA98; phi = 32'h7654_3210;
    repeat (5) tick(1'b0, 1'b0, 2'b10, plo, phi);
    chk(pop_o == 1'b0, "R6 no pop without word", pop_o, 0);
    chk(gray_vld_o == 1'b0 && gray_o == 4'd0, "R1 idle outputs after reset", gray_o, 0);
    tick(1'b0, 1'b1, 2'b10, plo, phi);
    chk(pop_o == 1'b1, "R6 pop when empty", pop_o, 1);
    // fixed-palette sweep over every depth code
    for (int m = 0; m < 4; m++) begin
      plo = rnd(); phi = rnd();
      for (int c = 0; c < 90; c++) tick(1'b1, 1'b1, 2'(m), plo, phi);
      drain(plo, phi);
    end
    // 1-bit mode with entries 0/1 distinct from the rest
    plo = 32'h5555_55A3; phi = 32'hFFFF_FFFF;
    for (int c = 0; c < 70; c++) tick(1'b1, 1'b1, 2'b00, plo, phi);
    drain(plo, phi);
    // irregular enables, gaps in the FIFO, depth changing every cycle
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] r = rnd();
      if (c % 7 == 0) begin plo = rnd(); phi = rnd(); end
      tick(r[0] | r[1], r[4:2] != 3'd0, r[9:8], plo, phi);
    end
    drain(plo, phi);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule